// File: doc/BRIEF.md
# Transmit Pause Holdoff Timer

This block stops a port from starting new data frames for a while after the link partner asks it to pause. The receive filter sends a one-cycle pulse and a 16-bit pause quantum when it decodes a pause request. The block loads that quantum into a down-counter. The counter then steps down once for each slot-time tick it receives. While the count is above zero, the transmit scheduler is told to hold off. Data frames are granted only when the transmit path is idle, so a frame that is already on the wire always finishes.

The station's own flow-control frames (pause and resume requests from the local pause generator) are granted whenever the path is idle, whatever the count. This lets the port push back on its peer even while it is itself held off. A status bit reports when the port is idle and held off, for a host-readable flow-control register. A new request reloads the counter. A request that carries a quantum of zero ends the holdoff at once.

Top module: `pause_holdoff`

## Requirements
- R1: A pause pulse loads the 16-bit counter with the accompanying quantum, and the new value is visible on the next clock.
- R2: Each slot tick without a pause pulse lowers a non-zero count by one. A count of zero stays at zero, and the count does not change in a cycle with neither a tick nor a pulse.
- R3: A pause pulse that arrives while the count is non-zero replaces the remaining count with the new quantum.
- R4: A pause pulse with quantum zero clears the counter, so `txInhibit` is low on the following cycle.
- R5: When a pause pulse and a slot tick occur in the same cycle, the counter takes the new quantum and is not decremented.
- R6: `dataGrant` is high exactly when `dataReq` is high, `txBusy` is low, `fcReq` is low and the count is zero.
- R7: `fcGrant` is high exactly when `fcReq` is high and `txBusy` is low, whatever the count. A local flow-control frame takes priority over a data frame in the same cycle.
- R8: While `txBusy` is high, no grant is given, so a frame in progress is never disturbed.
- R9: `txInhibit` is high exactly when the count is non-zero. `pausedStatus` is high exactly when `txInhibit` is high and `txBusy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pauseRxValid | input | 1 | One-cycle pulse: a pause request was received |
| pauseRxTime | input | 16 | Quantum carried by the received pause request |
| slotTick | input | 1 | One pulse per slot time |
| txBusy | input | 1 | Transmit path is sending a frame |
| dataReq | input | 1 | Scheduler wants to start a data frame |
| fcReq | input | 1 | Local pause generator wants to start a flow-control frame |
| dataGrant | output | 1 | Data frame may start this cycle |
| fcGrant | output | 1 | Flow-control frame may start this cycle |
| txInhibit | output | 1 | Holdoff active (count non-zero) |
| pausedStatus | output | 1 | Port idle and held off |

## Verification
Two counter events can fall in the same cycle: a reload from a received pause pulse and a decrement from the slot tick. The bench drives a pulse and a tick together at several points of a running countdown, including the last tick before zero. It judges the outcome by counting how many further ticks pass before `txInhibit` falls, which must match the new quantum exactly. A second pairing, a local flow-control request and a data request in the same idle cycle, is covered by sweeping every combination of the grant inputs against both a zero and a non-zero count.

// File: rtl/pause_pkg.sv
package pause_pkg;
  localparam int unsigned QUANTUM_W = 16;

  typedef struct packed {
    logic load;
    logic dec;
  } cntCtl_t;
endpackage

// File: rtl/pause_cnt_dp.sv
module pause_cnt_dp
  import pause_pkg::*;
#(
  parameter int unsigned W = QUANTUM_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  cntCtl_t      ctl,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] count,
  output logic         cntZero
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (!rstN)
      count <= '0;
    else if (ctl.load)
      count <= loadVal;
    else if (ctl.dec)
      count <= count - ONE;
  end

  assign cntZero = (count == '0);
endmodule

// File: rtl/pause_ctl.sv
module pause_ctl
  import pause_pkg::*;
(
  input  logic    pauseRxValid,
  input  logic    slotTick,
  input  logic    cntZero,
  input  logic    txBusy,
  input  logic    dataReq,
  input  logic    fcReq,
  output cntCtl_t ctl,
  output logic    dataGrant,
  output logic    fcGrant,
  output logic    txInhibit,
  output logic    pausedStatus
);
  logic idle;

  always_comb begin
    ctl.load = pauseRxValid;
    ctl.dec  = slotTick && !pauseRxValid && !cntZero;
  end

  assign idle         = !txBusy;
  assign txInhibit    = !cntZero;
  assign pausedStatus = txInhibit && idle;
  assign fcGrant      = idle && fcReq;
  assign dataGrant    = idle && dataReq && !fcReq && cntZero;
endmodule

// File: rtl/pause_holdoff.sv
module pause_holdoff
  import pause_pkg::*;
#(
  parameter int unsigned W = QUANTUM_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         pauseRxValid,
  input  logic [W-1:0] pauseRxTime,
  input  logic         slotTick,
  input  logic         txBusy,
  input  logic         dataReq,
  input  logic         fcReq,
  output logic         dataGrant,
  output logic         fcGrant,
  output logic         txInhibit,
  output logic         pausedStatus
);
  cntCtl_t      ctl;
  logic [W-1:0] count;
  logic         cntZero;

  pause_ctl u_ctl (
    .pauseRxValid(pauseRxValid),
    .slotTick    (slotTick),
    .cntZero     (cntZero),
    .txBusy      (txBusy),
    .dataReq     (dataReq),
    .fcReq       (fcReq),
    .ctl         (ctl),
    .dataGrant   (dataGrant),
    .fcGrant     (fcGrant),
    .txInhibit   (txInhibit),
    .pausedStatus(pausedStatus)
  );

  pause_cnt_dp #(.W(W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .loadVal(pauseRxTime),
    .count  (count),
    .cntZero(cntZero)
  );
endmodule

// File: rtl/pause_holdoff_chk.sv
module pause_holdoff_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         pauseRxValid,
  input logic [W-1:0] pauseRxTime,
  input logic         slotTick,
  input logic         txBusy,
  input logic         dataReq,
  input logic         fcReq,
  input logic         dataGrant,
  input logic         fcGrant,
  input logic         txInhibit,
  input logic         pausedStatus,
  input logic [W-1:0] count
);
  // R1, R3, R5: a pulse always loads, tick or not
  p_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    pauseRxValid |=> count == $past(pauseRxTime));

  // R2: decrement on tick
  p_dec_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!pauseRxValid && slotTick && count != '0) |=> count == $past(count) - W'(1));

  // R2: hold without tick or pulse
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!pauseRxValid && !slotTick) |=> $stable(count));

  // R2: no wrap below zero
  p_floor_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!pauseRxValid && count == '0) |=> count == '0);

  // R4: zero quantum ends holdoff
  p_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pauseRxValid && pauseRxTime == '0) |=> !txInhibit);

  // R6: data grant only when free to send
  p_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    dataGrant |-> (count == '0 && dataReq && !fcReq));

  // R7: local flow-control frame passes the holdoff
  p_fc_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fcReq && !txBusy) |-> fcGrant);

  // R8: nothing granted mid-frame, at most one grant
  p_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    txBusy |-> !dataGrant && !fcGrant);
  p_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dataGrant, fcGrant}));

  // R9: status bit tracks idle holdoff
  p_status_r9: assert property (@(posedge clk) disable iff (!rstN)
    pausedStatus |-> (count != '0 && !txBusy));
endmodule

bind pause_holdoff pause_holdoff_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .pauseRxValid(pauseRxValid),
  .pauseRxTime (pauseRxTime),
  .slotTick    (slotTick),
  .txBusy      (txBusy),
  .dataReq     (dataReq),
  .fcReq       (fcReq),
  .dataGrant   (dataGrant),
  .fcGrant     (fcGrant),
  .txInhibit   (txInhibit),
  .pausedStatus(pausedStatus),
  .count       (count)
);

// File: tb/tb_pause_holdoff.sv
module tb_pause_holdoff;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pauseRxValid = 1'b0;
  logic [15:0] pauseRxTime = '0;
  logic        slotTick = 1'b0;
  logic        txBusy = 1'b0;
  logic        dataReq = 1'b0;
  logic        fcReq = 1'b0;
  logic        dataGrant, fcGrant, txInhibit, pausedStatus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pause_holdoff dut (
    .clk(clk), .rstN(rstN),
    .pauseRxValid(pauseRxValid), .pauseRxTime(pauseRxTime),
    .slotTick(slotTick), .txBusy(txBusy),
    .dataReq(dataReq), .fcReq(fcReq),
    .dataGrant(dataGrant), .fcGrant(fcGrant),
    .txInhibit(txInhibit), .pausedStatus(pausedStatus)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // advance one clock; inputs then change 2 ns after the edge
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic pulse(input int q, input bit tick);
    pauseRxValid = 1'b1;
    pauseRxTime  = 16'(q);
    slotTick     = tick;
    step();
    pauseRxValid = 1'b0;
    slotTick     = 1'b0;
  endtask

  // apply ticks until inhibit drops; return ticks consumed
  task automatic drain(output int n);
    n = 0;
    while (txInhibit && n < 70000) begin
      slotTick = 1'b1;
      step();
      n++;
    end
    slotTick = 1'b0;
  endtask

  initial begin
    int n;
    step(); step();
    #1;
    chk("R9 reset inhibit", int'(txInhibit), 0);
    chk("R9 reset status", int'(pausedStatus), 0);
    rstN = 1'b1;
    step();

    // R1/R2: exact countdown length for a sweep of quanta
    for (int q = 1; q <= 24; q++) begin
      pulse(q, 1'b0);
      #1 chk("R1 loaded", int'(txInhibit), 1);
      drain(n);
      chk("R2 ticks to zero", n, q);
    end

    // R2: no tick leaves count unchanged; later ticks still needed
    pulse(3, 1'b0);
    for (int i = 0; i < 10; i++) step();
    drain(n);
    chk("R2 hold without tick", n, 3);
    // R2: ticks at zero do nothing harmful
    slotTick = 1'b1; step(); step(); slotTick = 1'b0;
    #1 chk("R2 floor", int'(txInhibit), 0);

    // R3: reload mid-count replaces remainder
    for (int k = 1; k <= 6; k++) begin
      pulse(8, 1'b0);
      for (int i = 0; i < k; i++) begin slotTick = 1'b1; step(); end
      slotTick = 1'b0;
      pulse(5, 1'b0);
      drain(n);
      chk("R3 reload overrides", n, 5);
    end

    // R4: zero quantum ends holdoff immediately
    pulse(40, 1'b0);
    pulse(0, 1'b0);
    #1 chk("R4 zero clears", int'(txInhibit), 0);

    // R5: pulse and tick together, at several countdown points
    for (int k = 0; k <= 3; k++) begin
      pulse(4, 1'b0);
      for (int i = 0; i < k; i++) begin slotTick = 1'b1; step(); end
      pulse(6, 1'b1);
      drain(n);
      chk("R5 reload beats tick", n, 6);
    end
    pulse(1, 1'b0);
    pulse(2, 1'b1);
    drain(n);
    chk("R5 reload on last tick", n, 2);

    // R6-R9: all grant input combos at zero and non-zero count
    for (int inh = 0; inh < 2; inh++) begin
      if (inh == 1) pulse(1000, 1'b0);
      for (int c = 0; c < 8; c++) begin
        dataReq = c[0];
        fcReq   = c[1];
        txBusy  = c[2];
        #1;
        chk("R6 dataGrant", int'(dataGrant),
            int'(c[0] && !c[1] && !c[2] && inh == 0));
        chk("R7 fcGrant", int'(fcGrant), int'(c[1] && !c[2]));
        if (c[2]) chk("R8 busy no grant", int'(dataGrant || fcGrant), 0);
        chk("R9 inhibit", int'(txInhibit), inh);
        chk("R9 status", int'(pausedStatus), int'(inh == 1 && !c[2]));
        step();
      end
      dataReq = 1'b0; fcReq = 1'b0; txBusy = 1'b0;
    end
    pulse(0, 1'b0);
    #1 chk("R4 zero clears after sweep", int'(txInhibit), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule